// File: doc/BRIEF.md
# Burst SRAM access controller

This block is a synchronous, flow-through memory with one shared data path, modelled as separate data-in, data-out and output-enable ports. It holds a small array of 32-bit words. Each word is split into four byte lanes. At every rising clock edge the block sorts the cycle into one of four kinds: deselect, start of a burst, burst step or burst hold. It also decides whether the cycle reads or writes. A two-bit burst counter produces the low address bits inside a four-word group. The group base is taken from the external address when a burst starts.

Two address strobes can start a burst. The processor strobe takes priority, but it only counts when chip select 1 is low, and its first cycle is always a read. The controller strobe can write on its very first clock. Read data is flow-through: the word at the address captured on the latest edge appears in the same cycle. The output-enable input gates the bus combinationally. The bus is also forced off in these cases:
- on writes;
- while the device is deselected;
- on the first cycle after leaving the deselected state;
- after any write, until a strobe starts a new read.

Top module: `burst_sram_ctl`

## Requirements
- R1: A strobe cycle (effective processor strobe, or controller strobe low) selects the device only if cs1_n=0, cs2=1 and cs3_n=0. Otherwise the device becomes deselected: no array access, bus off, burst address kept, and later strobe-free cycles stay deselected.
- R2: The processor strobe takes effect only when cs1_n=0. When it is effective, the controller strobe is ignored. A processor strobe with cs1_n=1 and the controller strobe high counts as a burst step or hold.
- R3: A burst started by the processor strobe is always a read. All write inputs are ignored on that clock.
- R4: A burst started by the controller strobe, with write indicated, writes din at the loaded address on that same clock.
- R5: Write is indicated when wr_all_n=0, and then all four lanes are written. It is also indicated when wr_all_n=1, wr_byte_n=0 and some lane_n[i]=0; then only those lanes i (lane i = din bits 8i+7:8i) are written. Every other combination is a read.
- R6: With both strobes inactive on a selected device, adv_n=0 moves to the next burst address and adv_n=1 keeps the current one. In either case the cycle may read or write at that address.
- R7: The burst address low bits are seed XOR step count (interleaved, the default) or seed plus step count (linear, by parameter). They wrap after four steps. The upper address bits stay at their loaded value.
- R8: During a read cycle, dout holds the word at the address used at the latest rising edge, with no further register stage.
- R9: dq_oe is 0 on write cycles, while the device is deselected, and on the first cycle of a burst that starts from the deselected state.
- R10: On an otherwise enabled read cycle, dq_oe follows !oe_n combinationally within the cycle.
- R11: After any write, dq_oe stays 0 on step and hold reads until a strobe starts a read.
- R12: While rst is high and after it is released, the device is deselected with dq_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| cs1_n | input | 1 | Chip select 1, active low; also qualifies the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, priority |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Byte lane selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 32 | Write data |
| dout | output | 32 | Read data (flow-through) |
| dq_oe | output | 1 | Bus drive enable for dout |

## Verification
The bound checker checks these rules on every clock:
- the bus is never driven while oe_n is high;
- a processor-strobe start never produces lane write enables;
- the bus goes quiet after a write, after a deselecting strobe, and on the first cycle out of deselect;
- hold cycles and deselects leave the burst address untouched.

The bench scenarios show what the checker cannot:
- the returned data and the merged byte lanes;
- the interleaved wrap order;
- controller-strobe writes landing on the same clock;
- the post-write bus lock ending only on a strobe-started read;
- the combinational response to oe_n inside a cycle.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sel_q,
  output cyc_e             cyc,
  output logic             drop,
  output logic [LANES-1:0] lane_we
);
  logic cpu_go, ctl_go, chip_on;
  logic [LANES-1:0] wmask;

  always_comb begin
    cpu_go  = !strb_cpu_n && !cs1_n;
    ctl_go  = !strb_ctl_n && !cpu_go;
    chip_on = !cs1_n && cs2 && !cs3_n;
    if (!wr_all_n)       wmask = '1;
    else if (!wr_byte_n) wmask = ~lane_n;
    else                 wmask = '0;

    drop = 1'b0;
    if (cpu_go || ctl_go) begin
      cyc  = chip_on ? CYC_BEGIN : CYC_IDLE;
      drop = !chip_on;
    end else if (sel_q) begin
      cyc = adv_n ? CYC_HOLD : CYC_CONT;
    end else begin
      cyc = CYC_IDLE;
    end

    if ((cyc == CYC_BEGIN && !cpu_go) || cyc == CYC_CONT || cyc == CYC_HOLD)
      lane_we = wmask;
    else
      lane_we = '0;
  end
endmodule

// File: rtl/sbc_burst.sv
module sbc_burst #(
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] seed,
  output logic [1:0] lo_cur,
  output logic [1:0] lo_nxt
);
  logic [1:0] seed_q, cnt_q, cnt_p1;

  assign cnt_p1 = cnt_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      seed_q <= seed;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_p1;
    end
  end

  generate
    if (INTERLEAVE) begin : g_ilv
      assign lo_cur = seed_q ^ cnt_q;
      assign lo_nxt = seed_q ^ cnt_p1;
    end else begin : g_lin
      assign lo_cur = seed_q + cnt_q;
      assign lo_nxt = seed_q + cnt_p1;
    end
  endgenerate
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [$clog2(DEPTH)-1:0]  waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [$clog2(DEPTH)-1:0]  raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
        if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
  endgenerate
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import sram_burst_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter bit INTERLEAVE = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int LANES     = 4,
  localparam int LANE_W    = 8,
  localparam int DW        = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_oe
);
  localparam int UPW = AW - 2;

  cyc_e             cyc;
  logic             drop, is_wr, is_begin, is_step;
  logic [LANES-1:0] lane_we;
  logic [UPW-1:0]   base_q;
  logic             sel_q, rd_q, fresh_q, lock_q;
  logic [1:0]       lo_cur, lo_nxt;
  logic [AW-1:0]    cur_addr, wr_addr;

  sbc_decode #(.LANES(LANES)) u_dec (
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .sel_q(sel_q), .cyc(cyc), .drop(drop), .lane_we(lane_we)
  );

  assign is_wr    = |lane_we;
  assign is_begin = (cyc == CYC_BEGIN);
  assign is_step  = (cyc == CYC_CONT);

  sbc_burst #(.INTERLEAVE(INTERLEAVE)) u_burst (
    .clk(clk), .rst(rst), .load(is_begin), .step(is_step),
    .seed(addr[1:0]), .lo_cur(lo_cur), .lo_nxt(lo_nxt)
  );

  assign cur_addr = {base_q, lo_cur};

  always_comb begin
    if (is_begin)     wr_addr = addr;
    else if (is_step) wr_addr = {base_q, lo_nxt};
    else              wr_addr = cur_addr;
  end

  sbc_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(lane_we), .waddr(wr_addr), .wdata(din),
    .raddr(cur_addr), .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      fresh_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (is_begin) begin
      base_q  <= addr[AW-1:2];
      sel_q   <= 1'b1;
      fresh_q <= !sel_q;
      rd_q    <= !is_wr;
      lock_q  <= is_wr;
    end else if (cyc == CYC_CONT || cyc == CYC_HOLD) begin
      fresh_q <= 1'b0;
      rd_q    <= !is_wr;
      lock_q  <= lock_q || is_wr;
    end else if (drop) begin
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
    end
  end

  assign dq_oe = sel_q && rd_q && !fresh_q && !lock_q && !oe_n;
endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk
  import sram_burst_pkg::*;
#(
  parameter int UPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           cs1_n,
  input logic           strb_cpu_n,
  input logic           strb_ctl_n,
  input logic           oe_n,
  input logic           dq_oe,
  input logic [3:0]     lane_we,
  input cyc_e           cyc,
  input logic           sel_q,
  input logic [1:0]     lo_cur,
  input logic [UPW-1:0] base_q
);
  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !oe_n);

  // R3
  cpu_start_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && !cs1_n) |-> (lane_we == 4'b0000));

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |=> !dq_oe);

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_IDLE && ((!strb_cpu_n && !cs1_n) || !strb_ctl_n))
      |=> (!dq_oe && $stable(base_q) && $stable(lo_cur)));

  // R9
  fresh_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_BEGIN && !sel_q) |=> !dq_oe);

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_HOLD) |=> ($stable(lo_cur) && $stable(base_q)));
endmodule

bind burst_sram_ctl burst_sram_ctl_chk #(.UPW(UPW)) u_chk (
  .clk(clk), .rst(rst), .cs1_n(cs1_n), .strb_cpu_n(strb_cpu_n),
  .strb_ctl_n(strb_ctl_n), .oe_n(oe_n), .dq_oe(dq_oe), .lane_we(lane_we),
  .cyc(cyc), .sel_q(sel_q), .lo_cur(lo_cur), .base_q(base_q)
);

// File: tb/sim_burst_sram_ctl.sv
module sim_burst_sram_ctl;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0] lane_n = 4'hF;
  logic oe_n = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic dq_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] mm [DEPTH];
  bit m_sel = 0, m_rd = 0, m_fresh = 0, m_lock = 0;
  int m_base = 0, m_k = 0;

  always #10 clk = ~clk;

  burst_sram_ctl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  function automatic int cur_a(int k);
    int s = m_base % 4;
    return (m_base / 4) * 4 + (s ^ (k % 4));   // interleaved order
  endfunction

  task automatic put(int a, logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (m[i]) mm[a][i*8 +: 8] = din[i*8 +: 8];
  endtask

  task automatic model_edge();
    bit p, c, en;
    logic [3:0] m;
    p  = !strb_cpu_n && !cs1_n;
    c  = !strb_ctl_n && !p;
    en = !cs1_n && cs2 && !cs3_n;
    m  = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
    if (p || c) begin
      if (!en) begin
        m_sel = 0; m_rd = 0;
      end else begin
        m_fresh = !m_sel; m_sel = 1; m_base = int'(addr); m_k = 0;
        if (p || m == 0) begin m_rd = 1; m_lock = 0; end
        else begin put(m_base, m); m_rd = 0; m_lock = 1; end
      end
    end else if (m_sel) begin
      m_fresh = 0;
      if (!adv_n) m_k++;
      if (m != 0) begin put(cur_a(m_k), m); m_rd = 0; m_lock = 1; end
      else m_rd = 1;
    end
  endtask

  function automatic bit exp_oe();
    return m_sel && m_rd && !m_fresh && !m_lock && !oe_n;
  endfunction

  task automatic check(string tag);
    bit eo = exp_oe();
    checks++;
    if (dq_oe !== eo) begin
      errors++;
      $display("FAIL %s dq_oe actual=%b expected=%b", tag, dq_oe, eo);
    end else if (eo) begin
      checks++;
      if (dout !== mm[cur_a(m_k)]) begin
        errors++;
        $display("FAIL %s dout actual=%h expected=%h", tag, dout, mm[cur_a(m_k)]);
      end
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    cs1_n = 0; cs2 = 1; cs3_n = 0; strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; oe_n = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin errors++; $display("FAIL R12 dq_oe actual=%b expected=0", dq_oe); end
    rst = 0;
    quiet();
    tick("R12");

    // fill the array with controller-strobe writes (R4, R5 full word)
    for (int i = 0; i < DEPTH; i++) begin
      quiet(); strb_ctl_n = 0; wr_all_n = 0; addr = AW'(i); din = 32'hA500_0000 + i * 32'h0101_0003;
      tick("R4");
    end

    // processor strobe with all write inputs active: read (R3)
    quiet(); strb_cpu_n = 0; addr = 6'd5; wr_all_n = 0; wr_byte_n = 0; lane_n = 4'h0; din = 32'hDEAD_BEEF;
    tick("R3");
    // interleaved burst 5,4,7,6 then wrap to 5 (R7)
    for (int i = 0; i < 4; i++) begin quiet(); adv_n = 0; tick("R7"); end
    quiet(); tick("R6");
    // output enable gating, combinational inside the cycle (R10)
    quiet(); oe_n = 1; tick("R10");
    oe_n = 0; #1; check("R10");
    // both strobes with write: processor wins, read at 9 (R2)
    quiet(); strb_cpu_n = 0; strb_ctl_n = 0; wr_all_n = 0; addr = 6'd9; din = 32'h1111_2222;
    tick("R2");
    // step write of lanes 0 and 2 to next address (R5, R9)
    quiet(); adv_n = 0; wr_byte_n = 0; lane_n = 4'b1010; din = 32'hAABB_CCDD;
    tick("R5");
    // hold read after write stays off (R11)
    quiet(); tick("R11");
    // controller-strobe read of the merged word (R5, R8)
    quiet(); strb_ctl_n = 0; addr = 6'd8; wr_byte_n = 0; lane_n = 4'hF;
    tick("R5");
    // cs1 high processor strobe is a burst step (R2)
    quiet(); cs1_n = 1; strb_cpu_n = 0; adv_n = 0; tick("R2");
    // deselect by cs2 low (R1), then strobe-free cycle stays off
    quiet(); strb_ctl_n = 0; cs2 = 0; addr = 6'd30; tick("R1");
    quiet(); adv_n = 0; wr_all_n = 0; din = 32'h0; tick("R1");
    // start from deselect: first cycle masked, then on (R9)
    quiet(); strb_cpu_n = 0; addr = 6'd10; tick("R9");
    quiet(); tick("R9");
    // processor strobe ignored (cs1 high) with controller strobe: deselect (R2)
    quiet(); cs1_n = 1; strb_cpu_n = 0; strb_ctl_n = 0; tick("R2");
    // controller write then hold read locked, processor read recovers (R4, R11)
    quiet(); strb_ctl_n = 0; wr_all_n = 0; addr = 6'd33; din = 32'h5A5A_0F0F; tick("R4");
    quiet(); tick("R11");
    quiet(); strb_cpu_n = 0; addr = 6'd33; tick("R4");
    quiet(); strb_cpu_n = 0; addr = 6'd33; tick("R8");

    // randomized traffic compared against the model every cycle (R8)
    for (int i = 0; i < 1500; i++) begin
      quiet();
      strb_cpu_n = ($urandom % 7) != 0;
      strb_ctl_n = ($urandom % 7) != 0;
      cs1_n = ($urandom % 10) == 0;
      cs2   = ($urandom % 10) != 0;
      cs3_n = ($urandom % 10) == 0;
      adv_n = $urandom % 2;
      wr_all_n = ($urandom % 8) != 0;
      wr_byte_n = ($urandom % 3) != 0;
      lane_n = 4'($urandom);
      oe_n = ($urandom % 5) == 0;
      addr = AW'($urandom);
      din = $urandom;
      tick("R8");
    end
    summary();
  end
endmodule